// File: doc/BRIEF.md
# Capsule Security Attribute Table

This block is the on-chip cache of per-capsule protection attributes that a secure processor consults whenever a cache line crosses the chip boundary. Each TLB entry carries a small table index. When a line is filled from external memory or a dirty line is evicted, the memory unit presents that index together with the capsule ID it expects. One cycle later the table answers with the capsule's cipher key, its integrity root signature and two control flags: use-encryption and use-authentication. When the use-encryption flag is clear, the answer also signals pass-through, so the datapath skips decryption.

A trusted kernel writes one entry at a time through a load port. It can clear every entry at once with an invalidate-all strobe. If a lookup lands on an empty slot or on a slot holding a different capsule, the answer is a one-cycle fault and carries no key material. The kernel then flushes the cache, reloads the entry and fixes the TLB indexes. After an eviction, the hash engine writes the freshly computed root signature back through a signature-update port. Keys arrive in plaintext, because the cipher, the hash tree and the key unwrapping sit outside the block.

Top module: `capsule_attr_table`

## Requirements
- R1: After reset every slot is empty and no response is flagged, so the first lookup of any slot faults.
- R2: A load writes key, signature, capsule ID and both flags of one slot and makes the slot valid in the same cycle. A lookup issued in cycle t returns that slot's contents on the outputs registered at the end of cycle t.
- R3: A lookup of an empty slot raises the fault output for exactly that response cycle and drives key, signature, flags and pass-through to zero.
- R4: A lookup whose expected capsule ID differs from the stored ID faults in the same way as R3.
- R5: On a hit, pass-through is 1 when the stored use-encryption flag is 0, and pass-through is 0 otherwise.
- R6: On a hit, the use-authentication flag is returned as stored.
- R7: The response-valid output is 1 exactly one cycle after each lookup request and 0 otherwise. The response kind echoes the request kind (0 = miss fill, 1 = eviction).
- R8: A signature update addressed to a valid slot with a matching capsule ID replaces that slot's signature and leaves its key unchanged.
- R9: A signature update addressed to an empty slot, or carrying a different capsule ID, has no effect.
- R10: Invalidate-all empties every slot and takes priority over a load in the same cycle.
- R11: When a load and a signature update target the same slot in the same cycle, the signature from the load is kept.
- R12: A lookup in the same cycle as a load to the same slot returns the contents from before the load.
- R13: A write to one slot leaves all other slots unchanged, including the highest-numbered slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inv_all_i | input | 1 | Empty every slot |
| ld_en_i | input | 1 | Kernel load strobe |
| ld_idx_i | input | IDX_W | Slot written by the load |
| ld_key_i | input | KEY_W | Plaintext cipher key |
| ld_sig_i | input | SIG_W | Root signature |
| ld_id_i | input | ID_W | Capsule ID |
| ld_use_enc_i | input | 1 | Use-encryption flag |
| ld_use_auth_i | input | 1 | Use-authentication flag |
| lk_req_i | input | 1 | Lookup request |
| lk_kind_i | input | 1 | 0 = miss fill, 1 = eviction |
| lk_idx_i | input | IDX_W | Slot index from the TLB entry |
| lk_id_i | input | ID_W | Expected capsule ID |
| su_en_i | input | 1 | Signature update strobe |
| su_idx_i | input | IDX_W | Slot to update |
| su_id_i | input | ID_W | Capsule ID the update belongs to |
| su_sig_i | input | SIG_W | New root signature |
| rsp_valid_o | output | 1 | Response present |
| rsp_kind_o | output | 1 | Echoed request kind |
| rsp_fault_o | output | 1 | Missing or mismatched attributes |
| rsp_key_o | output | KEY_W | Key (zero on fault) |
| rsp_sig_o | output | SIG_W | Root signature (zero on fault) |
| rsp_use_enc_o | output | 1 | Use-encryption flag |
| rsp_use_auth_o | output | 1 | Use-authentication flag |
| rsp_bypass_o | output | 1 | Pass-through, decryption skipped |

## Verification
The bench builds the table with 8 slots, 32-bit keys and signatures and 8-bit capsule IDs. With only 8 slots, both the lowest and the highest slot can be reached directly, and a bench-side shadow model stays small. The short fields make every returned key and signature fully comparable. Same-cycle collisions (load with lookup, load with signature update, load with invalidate-all) are driven as directed cases after the vector walk.

// File: rtl/capsule_attr_pkg.sv
package capsule_attr_pkg;
  typedef enum logic {
    ACC_FILL  = 1'b0,
    ACC_EVICT = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/cat_rst_sync.sv
module cat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cat_entry_store.sv
module cat_entry_store #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 128,
  parameter int SIG_W   = 128,
  parameter int ID_W    = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [KEY_W-1:0] ld_key_i,
  input  logic [SIG_W-1:0] ld_sig_i,
  input  logic [ID_W-1:0]  ld_id_i,
  input  logic             ld_use_enc_i,
  input  logic             ld_use_auth_i,
  input  logic             su_en_i,
  input  logic [IDX_W-1:0] su_idx_i,
  input  logic [ID_W-1:0]  su_id_i,
  input  logic [SIG_W-1:0] su_sig_i,
  output logic [ENTRIES-1:0] valid_o,
  output logic [KEY_W-1:0] key_o   [ENTRIES],
  output logic [SIG_W-1:0] sig_o   [ENTRIES],
  output logic [ID_W-1:0]  id_o    [ENTRIES],
  output logic [ENTRIES-1:0] use_enc_o,
  output logic [ENTRIES-1:0] use_auth_o
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic             vld_q, vld_d;
    logic [KEY_W-1:0] key_q;
    logic [SIG_W-1:0] sig_q, sig_d;
    logic [ID_W-1:0]  id_q;
    logic             enc_q, auth_q;
    logic             ld_hit, su_hit, sig_en;

    // next-state
    always_comb begin
      ld_hit = ld_en_i && (ld_idx_i == IDX_W'(i));
      su_hit = su_en_i && (su_idx_i == IDX_W'(i)) && vld_q && (id_q == su_id_i);
      sig_en = ld_hit || su_hit;
      // a load owns the slot this cycle, so its signature wins (R11)
      sig_d  = ld_hit ? ld_sig_i : su_sig_i;
      if (inv_all_i) begin
        vld_d = 1'b0;            // invalidate-all beats a load (R10)
      end else if (ld_hit) begin
        vld_d = 1'b1;
      end else begin
        vld_d = vld_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
      end else begin
        vld_q <= vld_d;
      end
    end

    always_ff @(posedge clk) begin
      if (ld_hit) begin
        key_q  <= ld_key_i;
        id_q   <= ld_id_i;
        enc_q  <= ld_use_enc_i;
        auth_q <= ld_use_auth_i;
      end
    end

    always_ff @(posedge clk) begin
      if (sig_en) begin
        sig_q <= sig_d;
      end
    end

    assign valid_o[i]    = vld_q;
    assign key_o[i]      = key_q;
    assign sig_o[i]      = sig_q;
    assign id_o[i]       = id_q;
    assign use_enc_o[i]  = enc_q;
    assign use_auth_o[i] = auth_q;
  end

  a_r10_inv_clears_all: assert property (
    @(posedge clk) disable iff (!rst_n)
    inv_all_i |=> (valid_o == '0)
  );

  a_r2_load_sets_valid: assert property (
    @(posedge clk) disable iff (!rst_n)
    (ld_en_i && !inv_all_i && ({1'b0, ld_idx_i} < (IDX_W+1)'(ENTRIES)))
      |=> valid_o[$past(ld_idx_i)]
  );
endmodule

// File: rtl/cat_lookup.sv
module cat_lookup
  import capsule_attr_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 128,
  parameter int SIG_W   = 128,
  parameter int ID_W    = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req_i,
  input  logic             lk_kind_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [ID_W-1:0]  lk_id_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [KEY_W-1:0] key_i   [ENTRIES],
  input  logic [SIG_W-1:0] sig_i   [ENTRIES],
  input  logic [ID_W-1:0]  id_i    [ENTRIES],
  input  logic [ENTRIES-1:0] use_enc_i,
  input  logic [ENTRIES-1:0] use_auth_i,
  output logic             rsp_valid_o,
  output logic             rsp_kind_o,
  output logic             rsp_fault_o,
  output logic [KEY_W-1:0] rsp_key_o,
  output logic [SIG_W-1:0] rsp_sig_o,
  output logic             rsp_use_enc_o,
  output logic             rsp_use_auth_o,
  output logic             rsp_bypass_o
);

  logic             rd_vld, rd_enc, rd_auth, hit;
  logic [KEY_W-1:0] rd_key;
  logic [SIG_W-1:0] rd_sig;
  logic [ID_W-1:0]  rd_id;

  logic             valid_d, fault_d, enc_d, auth_d, byp_d;
  acc_kind_e        kind_d;
  logic [KEY_W-1:0] key_d;
  logic [SIG_W-1:0] sig_d;

  // read mux; an index past the last slot reads as empty
  always_comb begin
    rd_vld  = 1'b0;
    rd_enc  = 1'b0;
    rd_auth = 1'b0;
    rd_key  = '0;
    rd_sig  = '0;
    rd_id   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_idx_i == IDX_W'(i)) begin
        rd_vld  = valid_i[i];
        rd_enc  = use_enc_i[i];
        rd_auth = use_auth_i[i];
        rd_key  = key_i[i];
        rd_sig  = sig_i[i];
        rd_id   = id_i[i];
      end
    end
  end

  // next-state of the response stage
  always_comb begin
    hit     = rd_vld && (rd_id == lk_id_i);
    valid_d = lk_req_i;
    kind_d  = acc_kind_e'(lk_kind_i);
    fault_d = lk_req_i && !hit;
    key_d   = (lk_req_i && hit) ? rd_key : '0;
    sig_d   = (lk_req_i && hit) ? rd_sig : '0;
    enc_d   = lk_req_i && hit && rd_enc;
    auth_d  = lk_req_i && hit && rd_auth;
    byp_d   = lk_req_i && hit && !rd_enc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o    <= 1'b0;
      rsp_kind_o     <= ACC_FILL;
      rsp_fault_o    <= 1'b0;
      rsp_key_o      <= '0;
      rsp_sig_o      <= '0;
      rsp_use_enc_o  <= 1'b0;
      rsp_use_auth_o <= 1'b0;
      rsp_bypass_o   <= 1'b0;
    end else begin
      rsp_valid_o    <= valid_d;
      rsp_kind_o     <= kind_d;
      rsp_fault_o    <= fault_d;
      rsp_key_o      <= key_d;
      rsp_sig_o      <= sig_d;
      rsp_use_enc_o  <= enc_d;
      rsp_use_auth_o <= auth_d;
      rsp_bypass_o   <= byp_d;
    end
  end

  a_r7_response_follows: assert property (
    @(posedge clk) disable iff (!rst_n)
    lk_req_i |=> (rsp_valid_o && (rsp_kind_o == $past(lk_kind_i)))
  );

  a_r7_no_spurious_response: assert property (
    @(posedge clk) disable iff (!rst_n)
    !lk_req_i |=> !rsp_valid_o
  );

  a_r3_fault_blanks_secrets: assert property (
    @(posedge clk) disable iff (!rst_n)
    rsp_fault_o |-> (rsp_valid_o && rsp_key_o == '0 && rsp_sig_o == '0 && !rsp_use_enc_o)
  );

  a_r5_bypass_only_on_plain_hit: assert property (
    @(posedge clk) disable iff (!rst_n)
    rsp_bypass_o |-> (rsp_valid_o && !rsp_fault_o && !rsp_use_enc_o)
  );
endmodule

// File: rtl/capsule_attr_table.sv
module capsule_attr_table #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 128,
  parameter int SIG_W   = 128,
  parameter int ID_W    = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [KEY_W-1:0] ld_key_i,
  input  logic [SIG_W-1:0] ld_sig_i,
  input  logic [ID_W-1:0]  ld_id_i,
  input  logic             ld_use_enc_i,
  input  logic             ld_use_auth_i,
  input  logic             lk_req_i,
  input  logic             lk_kind_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [ID_W-1:0]  lk_id_i,
  input  logic             su_en_i,
  input  logic [IDX_W-1:0] su_idx_i,
  input  logic [ID_W-1:0]  su_id_i,
  input  logic [SIG_W-1:0] su_sig_i,
  output logic             rsp_valid_o,
  output logic             rsp_kind_o,
  output logic             rsp_fault_o,
  output logic [KEY_W-1:0] rsp_key_o,
  output logic [SIG_W-1:0] rsp_sig_o,
  output logic             rsp_use_enc_o,
  output logic             rsp_use_auth_o,
  output logic             rsp_bypass_o
);

  logic               rst_sync_n;
  logic [ENTRIES-1:0] valid_w, enc_w, auth_w;
  logic [KEY_W-1:0]   key_w [ENTRIES];
  logic [SIG_W-1:0]   sig_w [ENTRIES];
  logic [ID_W-1:0]    id_w  [ENTRIES];

  cat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cat_entry_store #(
    .ENTRIES (ENTRIES), .KEY_W (KEY_W), .SIG_W (SIG_W), .ID_W (ID_W)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .inv_all_i     (inv_all_i),
    .ld_en_i       (ld_en_i),
    .ld_idx_i      (ld_idx_i),
    .ld_key_i      (ld_key_i),
    .ld_sig_i      (ld_sig_i),
    .ld_id_i       (ld_id_i),
    .ld_use_enc_i  (ld_use_enc_i),
    .ld_use_auth_i (ld_use_auth_i),
    .su_en_i       (su_en_i),
    .su_idx_i      (su_idx_i),
    .su_id_i       (su_id_i),
    .su_sig_i      (su_sig_i),
    .valid_o       (valid_w),
    .key_o         (key_w),
    .sig_o         (sig_w),
    .id_o          (id_w),
    .use_enc_o     (enc_w),
    .use_auth_o    (auth_w)
  );

  cat_lookup #(
    .ENTRIES (ENTRIES), .KEY_W (KEY_W), .SIG_W (SIG_W), .ID_W (ID_W)
  ) u_lookup (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .lk_req_i       (lk_req_i),
    .lk_kind_i      (lk_kind_i),
    .lk_idx_i       (lk_idx_i),
    .lk_id_i        (lk_id_i),
    .valid_i        (valid_w),
    .key_i          (key_w),
    .sig_i          (sig_w),
    .id_i           (id_w),
    .use_enc_i      (enc_w),
    .use_auth_i     (auth_w),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_kind_o     (rsp_kind_o),
    .rsp_fault_o    (rsp_fault_o),
    .rsp_key_o      (rsp_key_o),
    .rsp_sig_o      (rsp_sig_o),
    .rsp_use_enc_o  (rsp_use_enc_o),
    .rsp_use_auth_o (rsp_use_auth_o),
    .rsp_bypass_o   (rsp_bypass_o)
  );
endmodule

// File: tb/capsule_attr_table_tb_top.sv
`timescale 1ns/1ps
module capsule_attr_table_tb_top;
  localparam int ENT = 8;
  localparam int KW  = 32;
  localparam int SW  = 32;
  localparam int IW  = 8;

  localparam logic [1:0] OP_LD = 2'd0, OP_LK = 2'd1, OP_SU = 2'd2, OP_INV = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic        kind;
    logic [2:0]  idx;
    logic [7:0]  id;
    logic [31:0] data;
    logic        enc;
    logic        auth;
    logic        exp_fault;
  } vec_t;

  // load: key = data, sig = ~data ; signature update: sig = data
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_LD,  1'b0, 3'd1, 8'h11, 32'hA1A1_0001, 1'b1, 1'b1, 1'b0},
    '{OP_LD,  1'b0, 3'd7, 8'h77, 32'hB7B7_0007, 1'b0, 1'b1, 1'b0},
    '{OP_LK,  1'b0, 3'd1, 8'h11, 32'h0,         1'b0, 1'b0, 1'b0}, // R2 hit, fill
    '{OP_LK,  1'b1, 3'd7, 8'h77, 32'h0,         1'b0, 1'b0, 1'b0}, // R5 bypass, R13 top slot
    '{OP_LK,  1'b0, 3'd3, 8'h33, 32'h0,         1'b0, 1'b0, 1'b1}, // R3 empty slot
    '{OP_LK,  1'b0, 3'd1, 8'h12, 32'h0,         1'b0, 1'b0, 1'b1}, // R4 ID mismatch
    '{OP_SU,  1'b0, 3'd1, 8'h11, 32'hC1C1_00C1, 1'b0, 1'b0, 1'b0}, // R8
    '{OP_LK,  1'b1, 3'd1, 8'h11, 32'h0,         1'b0, 1'b0, 1'b0},
    '{OP_SU,  1'b0, 3'd7, 8'h78, 32'hDDDD_DDDD, 1'b0, 1'b0, 1'b0}, // R9 wrong ID
    '{OP_LK,  1'b0, 3'd7, 8'h77, 32'h0,         1'b0, 1'b0, 1'b0},
    '{OP_SU,  1'b0, 3'd3, 8'h33, 32'hEEEE_EEEE, 1'b0, 1'b0, 1'b0}, // R9 empty slot
    '{OP_LD,  1'b0, 3'd0, 8'h00, 32'h0000_0005, 1'b0, 1'b0, 1'b0},
    '{OP_LK,  1'b0, 3'd0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b0}, // R6 auth clear
    '{OP_LK,  1'b0, 3'd1, 8'h11, 32'h0,         1'b0, 1'b0, 1'b0}, // R13 neighbour intact
    '{OP_INV, 1'b0, 3'd0, 8'h00, 32'h0,         1'b0, 1'b0, 1'b0}, // R10
    '{OP_LK,  1'b0, 3'd1, 8'h11, 32'h0,         1'b0, 1'b0, 1'b1},
    '{OP_LK,  1'b1, 3'd7, 8'h77, 32'h0,         1'b0, 1'b0, 1'b1}
  };

  logic clk, rst_n;
  logic inv_all, ld_en, ld_enc, ld_auth, lk_req, lk_kind, su_en;
  logic [2:0]  ld_idx, lk_idx, su_idx;
  logic [KW-1:0] ld_key;
  logic [SW-1:0] ld_sig, su_sig;
  logic [IW-1:0] ld_id, lk_id, su_id;
  logic rsp_valid, rsp_kind, rsp_fault, rsp_enc, rsp_auth, rsp_byp;
  logic [KW-1:0] rsp_key;
  logic [SW-1:0] rsp_sig;

  int checks = 0;
  int errors = 0;

  logic          m_vld  [ENT];
  logic [KW-1:0] m_key  [ENT];
  logic [SW-1:0] m_sig  [ENT];
  logic [IW-1:0] m_id   [ENT];
  logic          m_enc  [ENT];
  logic          m_auth [ENT];

  capsule_attr_table #(.ENTRIES(ENT), .KEY_W(KW), .SIG_W(SW), .ID_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inv_all_i(inv_all),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_key_i(ld_key), .ld_sig_i(ld_sig),
    .ld_id_i(ld_id), .ld_use_enc_i(ld_enc), .ld_use_auth_i(ld_auth),
    .lk_req_i(lk_req), .lk_kind_i(lk_kind), .lk_idx_i(lk_idx), .lk_id_i(lk_id),
    .su_en_i(su_en), .su_idx_i(su_idx), .su_id_i(su_id), .su_sig_i(su_sig),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_fault_o(rsp_fault),
    .rsp_key_o(rsp_key), .rsp_sig_o(rsp_sig), .rsp_use_enc_o(rsp_enc),
    .rsp_use_auth_o(rsp_auth), .rsp_bypass_o(rsp_byp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    inv_all = 0; ld_en = 0; lk_req = 0; su_en = 0;
  endtask

  task automatic check_rsp(logic kind, logic f, logic [KW-1:0] k, logic [SW-1:0] s,
                           logic e, logic a);
    chk("R7 valid", rsp_valid, 1);
    chk("R7 kind", rsp_kind, kind);
    chk("R3 R4 fault", rsp_fault, f);
    chk("R2 R8 key", rsp_key, f ? '0 : k);
    chk("R2 R8 sig", rsp_sig, f ? '0 : s);
    chk("R5 enc", rsp_enc, f ? 1'b0 : e);
    chk("R6 auth", rsp_auth, f ? 1'b0 : a);
    chk("R5 bypass", rsp_byp, !f && !e);
  endtask

  initial begin
    idle();
    rst_n = 0; ld_idx = 0; ld_key = 0; ld_sig = 0; ld_id = 0; ld_enc = 0; ld_auth = 0;
    lk_kind = 0; lk_idx = 0; lk_id = 0; su_idx = 0; su_id = 0; su_sig = 0;
    for (int i = 0; i < ENT; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 rsp_fault after reset", rsp_fault, 0);
    lk_req = 1; lk_idx = 3'd0; lk_id = 8'h00; lk_kind = 0;
    @(negedge clk); idle();
    chk("R1 first lookup faults", rsp_fault, 1);
    @(negedge clk);
    chk("R3 fault lasts one cycle", rsp_fault, 0);
    chk("R7 no response without request", rsp_valid, 0);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      case (t.op)
        OP_LD: begin
          ld_en = 1; ld_idx = t.idx; ld_key = t.data; ld_sig = ~t.data;
          ld_id = t.id; ld_enc = t.enc; ld_auth = t.auth;
          m_vld[t.idx] = 1; m_key[t.idx] = t.data; m_sig[t.idx] = ~t.data;
          m_id[t.idx] = t.id; m_enc[t.idx] = t.enc; m_auth[t.idx] = t.auth;
        end
        OP_SU: begin
          su_en = 1; su_idx = t.idx; su_id = t.id; su_sig = t.data;
          if (m_vld[t.idx] && m_id[t.idx] == t.id) m_sig[t.idx] = t.data; // R8, else R9
        end
        OP_INV: begin
          inv_all = 1;
          for (int i = 0; i < ENT; i++) m_vld[i] = 0; // R10
        end
        default: begin
          lk_req = 1; lk_kind = t.kind; lk_idx = t.idx; lk_id = t.id;
        end
      endcase
      @(negedge clk);
      idle();
      if (t.op == OP_LK)
        check_rsp(t.kind, t.exp_fault, m_key[t.idx], m_sig[t.idx],
                  m_enc[t.idx], m_auth[t.idx]);
    end

    // R12: lookup in the load cycle sees old contents
    ld_en = 1; ld_idx = 3'd2; ld_key = 32'h1111_2222; ld_sig = 32'h3333_4444;
    ld_id = 8'h22; ld_enc = 1; ld_auth = 0;
    @(negedge clk); idle();
    ld_en = 1; ld_idx = 3'd2; ld_key = 32'h5555_6666; ld_sig = 32'h7777_8888;
    lk_req = 1; lk_idx = 3'd2; lk_id = 8'h22; lk_kind = 1;
    @(negedge clk); idle();
    chk("R12 old key during load", rsp_key, 32'h1111_2222);
    lk_req = 1;
    @(negedge clk); idle();
    chk("R12 new key after load", rsp_key, 32'h5555_6666);

    // R11: load and signature update to the same slot
    ld_en = 1; ld_idx = 3'd2; ld_key = 32'h0A0A_0A0A; ld_sig = 32'h0B0B_0B0B; ld_id = 8'h22;
    su_en = 1; su_idx = 3'd2; su_id = 8'h22; su_sig = 32'h0C0C_0C0C;
    @(negedge clk); idle();
    lk_req = 1; lk_idx = 3'd2; lk_id = 8'h22;
    @(negedge clk); idle();
    chk("R11 load signature wins", rsp_sig, 32'h0B0B_0B0B);

    // R10: invalidate-all beats a same-cycle load
    inv_all = 1; ld_en = 1; ld_idx = 3'd5; ld_id = 8'h55; ld_key = 32'h5;
    @(negedge clk); idle();
    lk_req = 1; lk_idx = 3'd5; lk_id = 8'h55;
    @(negedge clk); idle();
    chk("R10 load under invalidate dropped", rsp_fault, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule